// File: doc/BRIEF.md
# Translation Buffer with Domain Access Check

This block translates 32-bit virtual addresses to physical addresses through a fully associative store of cached translations. Each cached translation covers either a 1 MB section or a 4 KB page. Each one also names one of sixteen protection domains, carries a 2-bit permission code, and carries bufferable and cacheable attributes. A 32-bit domain-control input gives two bits of mode per domain. The mode either blocks the domain, grants it outright, or defers to the permission code of the matching translation.

A request is accepted while `req_ready` is high. The block answers a hit or a bypassed request (translation disabled) one cycle later. On a miss it raises `walk_req` with the faulting address and waits for an external walker to return the entry on the refill port. It stores the entry in the next round-robin slot, looks the held address up again, and then answers. A flush clears the whole store in one cycle.

The controller has three states: IDLE (accepts requests), WALK (waits for the refill) and REPLAY (looks up the refilled address once). The transitions are:
- IDLE→IDLE on a hit or a bypass, loading a response.
- IDLE→WALK on a miss.
- WALK→WALK while no refill arrives.
- WALK→REPLAY when the refill arrives.
- REPLAY→IDLE, loading a response.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `walk_req` are 0, and every slot is empty, so the first translated request misses.
- R2: A request accepted with `xl_en`=0 gives `resp_valid` on the next cycle with `resp_paddr` equal to the request address, `resp_abort`=0 and both attribute outputs 0. It never starts a walk, even if the address is cached.
- R3: A translated request that matches no slot raises `walk_req` on the next cycle with `walk_vaddr` equal to the request address and `req_ready` low. Both hold until `fill_valid` is seen.
- R4: The refill is taken in the cycle `fill_valid` is high during a walk. The response appears two cycles later, and the stored tag is the held request address.
- R5: A translated request that hits answers on the next cycle without raising `walk_req`.
- R6: A section entry (`fill_section`=1) matches on address bits 31:20 and gives `{fill_frame[19:8], vaddr[19:0]}`. A page entry matches on bits 31:12 and gives `{fill_frame, vaddr[11:0]}`.
- R7: The mode of domain d is `dom_ctrl[2d+1:2d]`. 00 aborts, 10 aborts, 11 allows regardless of permissions, and 01 applies the permission code. The mode is read at lookup time, so a changed `dom_ctrl` affects cached entries.
- R8: The permission code `fill_perm` works as follows: 00 aborts every access, 01 aborts unless `req_priv`=1, 10 aborts any write, and 11 allows all accesses.
- R9: An aborted response gives `resp_paddr`=0 and both attribute outputs 0. An allowed translated response carries the entry's bufferable and cacheable bits.
- R10: `flush` empties every slot at the edge where it is seen, so a later request to a previously cached address misses.
- R11: Refills fill slots 0,1,…,63 in turn and then wrap to slot 0; `flush` sends the pointer back to slot 0. After 65 refills following a flush, the first one is evicted and the second is still held.
- R12: When more than one valid slot matches, the lowest-numbered slot supplies the translation.
- R13: `req_valid` is ignored while `req_ready` is low. It changes neither `walk_vaddr` nor the response, and it adds no extra response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xl_en | input | 1 | Translation enable; 0 passes addresses through |
| flush | input | 1 | Invalidate all slots |
| dom_ctrl | input | 32 | Two mode bits per domain |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_priv | input | 1 | 1 = privileged access |
| resp_valid | output | 1 | Response valid, one cycle |
| resp_paddr | output | 32 | Physical address |
| resp_abort | output | 1 | Access refused |
| resp_bufable | output | 1 | Bufferable attribute |
| resp_cacheable | output | 1 | Cacheable attribute |
| walk_req | output | 1 | Table walk wanted |
| walk_vaddr | output | 32 | Address to walk |
| fill_valid | input | 1 | Refill entry present |
| fill_section | input | 1 | 1 = 1 MB section, 0 = 4 KB page |
| fill_frame | input | 20 | Physical frame bits 31:12 |
| fill_dom | input | 4 | Domain number |
| fill_perm | input | 2 | Permission code |
| fill_bufable | input | 1 | Bufferable bit |
| fill_cacheable | input | 1 | Cacheable bit |

## Verification
The properties take for granted that a refill arrives only while `walk_req` is high. They also assume that `flush` never coincides with a refill, and that `xl_en`, `dom_ctrl` and the request fields are meaningful in the cycle a request is accepted. The stimulus changes every input on the falling clock edge. It drives `fill_valid` only after it has seen `walk_req`, and it pulses `flush` only while the controller is idle with no request present. The one deliberate violation of the handshake, a request offered during a walk, is what R13 exercises.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_SHIFT  = 12;
    localparam int SECT_SHIFT  = 20;
    localparam int TAG_W       = ADDR_W - PAGE_SHIFT;
    localparam int SECT_TAG_W  = ADDR_W - SECT_SHIFT;
    localparam int NUM_DOMAINS = 16;
    localparam int DOM_W       = $clog2(NUM_DOMAINS);
    localparam int DCR_W       = 2 * NUM_DOMAINS;

    typedef enum logic [1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        AP_NONE   = 2'b00,
        AP_PRIV   = 2'b01,
        AP_RDONLY = 2'b10,
        AP_FULL   = 2'b11
    } perm_e;

    typedef struct packed {
        logic             section;
        logic [TAG_W-1:0] frame;
        logic [DOM_W-1:0] dom;
        perm_e            perm;
        logic             bufable;
        logic             cacheable;
    } entry_attr_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WALK   = 2'b01,
        ST_REPLAY = 2'b10
    } ctrl_state_e;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  entry_attr_t      wr_attr,
    input  logic [TAG_W-1:0] lk_vpn,
    output logic             lk_hit,
    output entry_attr_t      lk_attr
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic [NUM_ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]       tag_q  [NUM_ENTRIES];
    entry_attr_t            attr_q [NUM_ENTRIES];
    logic [IDX_W-1:0]       victim_q;
    logic [NUM_ENTRIES-1:0] match;

    // One comparator per slot; sections ignore the low tag bits.
    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            logic sect_eq;
            logic page_eq;
            assign sect_eq  = tag_q[g][TAG_W-1 -: SECT_TAG_W] == lk_vpn[TAG_W-1 -: SECT_TAG_W];
            assign page_eq  = tag_q[g] == lk_vpn;
            assign match[g] = valid_q[g] && (attr_q[g].section ? sect_eq : page_eq);
        end
    endgenerate

    // Lowest-numbered matching slot wins.
    always_comb begin
        lk_hit  = |match;
        lk_attr = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) lk_attr = attr_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[victim_q]  <= wr_tag;
            attr_q[victim_q] <= wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else begin
            if (flush) begin
                valid_q  <= '0;
                victim_q <= '0;
            end
            if (wr_en) begin
                valid_q[victim_q] <= 1'b1;
                victim_q <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_access_check.sv
module xlat_access_check
    import xlat_pkg::*;
(
    input  logic [DCR_W-1:0] dom_ctrl,
    input  logic [DOM_W-1:0] dom,
    input  perm_e            perm,
    input  logic             is_write,
    input  logic             is_priv,
    output logic             allow
);
    dom_mode_e mode;

    always_comb begin
        mode = dom_mode_e'(dom_ctrl[2*dom +: 2]);
        unique case (mode)
            DOM_MANAGER: allow = 1'b1;
            DOM_CLIENT: begin
                unique case (perm)
                    AP_NONE:   allow = 1'b0;
                    AP_PRIV:   allow = is_priv;
                    AP_RDONLY: allow = !is_write;
                    AP_FULL:   allow = 1'b1;
                    default:   allow = 1'b0;
                endcase
            end
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlat_ctrl_fsm.sv
module xlat_ctrl_fsm
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic xl_en,
    input  logic lk_hit,
    input  logic fill_valid,
    output logic req_ready,
    output logic capture,
    output logic use_held,
    output logic walk_active,
    output logic fill_we,
    output logic rsp_load,
    output logic rsp_bypass
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && xl_en && !lk_hit) state_d = ST_WALK;
            ST_WALK:   if (fill_valid) state_d = ST_REPLAY;
            ST_REPLAY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready   = 1'b0;
        capture     = 1'b0;
        use_held    = 1'b0;
        walk_active = 1'b0;
        fill_we     = 1'b0;
        rsp_load    = 1'b0;
        rsp_bypass  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready  = 1'b1;
                capture    = req_valid;
                rsp_load   = req_valid && (!xl_en || lk_hit);
                rsp_bypass = !xl_en;
            end
            ST_WALK: begin
                walk_active = 1'b1;
                use_held    = 1'b1;
                fill_we     = fill_valid;
            end
            ST_REPLAY: begin
                use_held = 1'b1;
                rsp_load = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xl_en,
    input  logic              flush,
    input  logic [DCR_W-1:0]  dom_ctrl,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_abort,
    output logic              resp_bufable,
    output logic              resp_cacheable,
    output logic              walk_req,
    output logic [ADDR_W-1:0] walk_vaddr,
    input  logic              fill_valid,
    input  logic              fill_section,
    input  logic [TAG_W-1:0]  fill_frame,
    input  logic [DOM_W-1:0]  fill_dom,
    input  logic [1:0]        fill_perm,
    input  logic              fill_bufable,
    input  logic              fill_cacheable
);
    logic              capture, use_held, fill_we, rsp_load, rsp_bypass;
    logic              lk_hit, allow;
    entry_attr_t       lk_attr, fill_attr;
    logic [ADDR_W-1:0] held_vaddr, lk_vaddr, xpaddr;
    logic              held_write, held_priv, lk_write, lk_priv;

    xlat_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .xl_en      (xl_en),
        .lk_hit     (lk_hit),
        .fill_valid (fill_valid),
        .req_ready  (req_ready),
        .capture    (capture),
        .use_held   (use_held),
        .walk_active(walk_req),
        .fill_we    (fill_we),
        .rsp_load   (rsp_load),
        .rsp_bypass (rsp_bypass)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_vaddr <= '0;
            held_write <= 1'b0;
            held_priv  <= 1'b0;
        end else if (capture) begin
            held_vaddr <= req_vaddr;
            held_write <= req_write;
            held_priv  <= req_priv;
        end
    end

    assign lk_vaddr   = use_held ? held_vaddr : req_vaddr;
    assign lk_write   = use_held ? held_write : req_write;
    assign lk_priv    = use_held ? held_priv  : req_priv;
    assign walk_vaddr = held_vaddr;

    assign fill_attr.section   = fill_section;
    assign fill_attr.frame     = fill_frame;
    assign fill_attr.dom       = fill_dom;
    assign fill_attr.perm      = perm_e'(fill_perm);
    assign fill_attr.bufable   = fill_bufable;
    assign fill_attr.cacheable = fill_cacheable;

    xlat_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (fill_we),
        .wr_tag  (held_vaddr[ADDR_W-1:PAGE_SHIFT]),
        .wr_attr (fill_attr),
        .lk_vpn  (lk_vaddr[ADDR_W-1:PAGE_SHIFT]),
        .lk_hit  (lk_hit),
        .lk_attr (lk_attr)
    );

    xlat_access_check u_check (
        .dom_ctrl (dom_ctrl),
        .dom      (lk_attr.dom),
        .perm     (lk_attr.perm),
        .is_write (lk_write),
        .is_priv  (lk_priv),
        .allow    (allow)
    );

    assign xpaddr = lk_attr.section
        ? {lk_attr.frame[TAG_W-1 -: SECT_TAG_W], lk_vaddr[SECT_SHIFT-1:0]}
        : {lk_attr.frame, lk_vaddr[PAGE_SHIFT-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_paddr     <= '0;
            resp_abort     <= 1'b0;
            resp_bufable   <= 1'b0;
            resp_cacheable <= 1'b0;
        end else begin
            resp_valid <= rsp_load;
            if (rsp_load) begin
                if (rsp_bypass) begin
                    resp_paddr     <= lk_vaddr;
                    resp_abort     <= 1'b0;
                    resp_bufable   <= 1'b0;
                    resp_cacheable <= 1'b0;
                end else if (!allow) begin
                    resp_paddr     <= '0;
                    resp_abort     <= 1'b1;
                    resp_bufable   <= 1'b0;
                    resp_cacheable <= 1'b0;
                end else begin
                    resp_paddr     <= xpaddr;
                    resp_abort     <= 1'b0;
                    resp_bufable   <= lk_attr.bufable;
                    resp_cacheable <= lk_attr.cacheable;
                end
            end
        end
    end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              xl_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic              resp_abort,
    input logic              resp_bufable,
    input logic              resp_cacheable,
    input logic              walk_req,
    input logic [ADDR_W-1:0] walk_vaddr,
    input logic              fill_valid
);
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=>
            (resp_valid && !resp_abort && !walk_req && resp_paddr == $past(req_vaddr)));

    p_walk_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> (walk_vaddr == $past(req_vaddr) && !req_ready));

    p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vaddr)));

    p_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> (!walk_req ##1 resp_valid));

    p_resp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    p_abort_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_abort |-> (resp_paddr == '0 && !resp_bufable && !resp_cacheable));
endmodule

bind xlat_buffer xlat_buffer_chk u_chk (.*);

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;
    localparam real CLK_HALF = 2.5;
    localparam logic [31:0] DCR = 32'h0000_008D;

    typedef struct packed {
        logic        en;
        logic        wr;
        logic        pv;
        logic [31:0] va;
        logic [31:0] dcr;
        logic        miss;
        logic        fsect;
        logic [19:0] fframe;
        logic [3:0]  fdom;
        logic [1:0]  fperm;
        logic        fb;
        logic        fc;
        logic        abort;
        logic [31:0] pa;
        logic        b;
        logic        c;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b0,1'b0,32'h1234_5678,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h1234_5678,1'b0,1'b0,4'd2},  // R2 bypass
        '{1'b1,1'b0,1'b0,32'h0040_1ABC,DCR,1'b1,1'b0,20'h80123,4'h0,2'h3,1'b1,1'b0,1'b0,32'h8012_3ABC,1'b1,1'b0,4'd4},  // R3 R4 page miss
        '{1'b1,1'b1,1'b0,32'h0040_1004,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h8012_3004,1'b1,1'b0,4'd5},  // R5 hit
        '{1'b1,1'b1,1'b0,32'h0A5F_0123,DCR,1'b1,1'b1,20'h3C0FF,4'h1,2'h0,1'b0,1'b1,1'b0,32'h3C0F_0123,1'b0,1'b1,4'd7},  // R7 manager
        '{1'b1,1'b0,1'b0,32'h0A5A_BCDE,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h3C0A_BCDE,1'b0,1'b1,4'd6},  // R6 section
        '{1'b1,1'b0,1'b1,32'h0100_2000,DCR,1'b1,1'b0,20'h11111,4'h2,2'h3,1'b1,1'b1,1'b1,32'h0000_0000,1'b0,1'b0,4'd9},  // R9 R7 no access
        '{1'b1,1'b0,1'b1,32'h0100_3000,DCR,1'b1,1'b0,20'h22222,4'h3,2'h3,1'b1,1'b1,1'b1,32'h0000_0000,1'b0,1'b0,4'd7},  // R7 reserved
        '{1'b1,1'b0,1'b0,32'h0200_0010,DCR,1'b1,1'b0,20'h33333,4'h0,2'h1,1'b0,1'b0,1'b1,32'h0000_0000,1'b0,1'b0,4'd8},  // R8 user on priv
        '{1'b1,1'b1,1'b1,32'h0200_0010,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h3333_3010,1'b0,1'b0,4'd8},  // R8 priv ok
        '{1'b1,1'b1,1'b1,32'h0200_1020,DCR,1'b1,1'b0,20'h44444,4'h0,2'h2,1'b1,1'b1,1'b1,32'h0000_0000,1'b0,1'b0,4'd8},  // R8 write ro
        '{1'b1,1'b0,1'b0,32'h0200_1020,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h4444_4020,1'b1,1'b1,4'd9},  // R9 attrs
        '{1'b1,1'b0,1'b1,32'h0200_2030,DCR,1'b1,1'b0,20'h55555,4'h0,2'h0,1'b0,1'b0,1'b1,32'h0000_0000,1'b0,1'b0,4'd8},  // R8 none
        '{1'b1,1'b1,1'b0,32'h0200_2030,32'h0000_008F,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h5555_5030,1'b0,1'b0,4'd7}, // R7 live dcr
        '{1'b1,1'b0,1'b0,32'h0040_7777,DCR,1'b1,1'b1,20'h9AB00,4'h0,2'h3,1'b0,1'b0,1'b0,32'h9AB0_7777,1'b0,1'b0,4'd6},  // R6 section fill
        '{1'b1,1'b0,1'b0,32'h0040_1FFF,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h8012_3FFF,1'b1,1'b0,4'd12}, // R12 priority
        '{1'b0,1'b1,1'b0,32'h0040_1004,DCR,1'b0,1'b0,20'h00000,4'h0,2'h0,1'b0,1'b0,1'b0,32'h0040_1004,1'b0,1'b0,4'd2}   // R2 cached bypass
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0, flush = 1'b0;
    logic [31:0] dom_ctrl = DCR;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, resp_valid, resp_abort, resp_bufable, resp_cacheable;
    logic [31:0] resp_paddr, walk_vaddr;
    logic        walk_req;
    logic        fill_valid = 1'b0, fill_section = 1'b0, fill_bufable = 1'b0, fill_cacheable = 1'b0;
    logic [19:0] fill_frame = '0;
    logic [3:0]  fill_dom = '0;
    logic [1:0]  fill_perm = '0;

    int n_chk = 0;
    int n_bad = 0;
    vec_t dyn_v;

    always #(CLK_HALF) clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .flush(flush), .dom_ctrl(dom_ctrl),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_abort(resp_abort),
        .resp_bufable(resp_bufable), .resp_cacheable(resp_cacheable),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr),
        .fill_valid(fill_valid), .fill_section(fill_section), .fill_frame(fill_frame),
        .fill_dom(fill_dom), .fill_perm(fill_perm),
        .fill_bufable(fill_bufable), .fill_cacheable(fill_cacheable)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_access(input vec_t v, input string tag);
        @(negedge clk);
        xl_en = v.en; dom_ctrl = v.dcr;
        req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; req_priv = v.pv;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " walk_req"}, 32'(walk_req), 32'(v.miss));
        if (walk_req) begin
            check({tag, " walk_vaddr"}, walk_vaddr, v.va);
            fill_valid = 1'b1; fill_section = v.fsect; fill_frame = v.fframe;
            fill_dom = v.fdom; fill_perm = v.fperm;
            fill_bufable = v.fb; fill_cacheable = v.fc;
            @(negedge clk);
            fill_valid = 1'b0;
            @(negedge clk);
        end
        check({tag, " resp_valid"}, 32'(resp_valid), 32'd1);
        check({tag, " abort"}, 32'(resp_abort), 32'(v.abort));
        check({tag, " paddr"}, resp_paddr, v.pa);
        check({tag, " attrs"}, {30'd0, resp_bufable, resp_cacheable}, {30'd0, v.b, v.c});
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 100000.0);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 resp_valid", 32'(resp_valid), 32'd0);
        check("R1 walk_req", 32'(walk_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release ready", 32'(req_ready), 32'd1);

        for (int i = 0; i < NVEC; i++) begin
            do_access(VECS[i], $sformatf("R%0d vec%0d", VECS[i].rq, i));
        end

        // R10 flush empties the store
        do_flush();
        dyn_v = VECS[1];
        dyn_v.va = 32'h0040_1004; dyn_v.pa = 32'h8012_3004;
        do_access(dyn_v, "R10 after flush");

        // R11 round robin: 65 refills after a flush evict the first
        do_flush();
        for (int i = 0; i < 65; i++) begin
            dyn_v = '0;
            dyn_v.en = 1'b1; dyn_v.dcr = DCR; dyn_v.miss = 1'b1;
            dyn_v.va = 32'h0800_0000 + (32'(i) << 12);
            dyn_v.fframe = 20'h70000 + 20'(i); dyn_v.fdom = 4'h1; dyn_v.fperm = 2'h3;
            dyn_v.pa = {dyn_v.fframe, 12'h000};
            do_access(dyn_v, "R11 fill");
        end
        dyn_v.va = 32'h0800_1000; dyn_v.miss = 1'b0; dyn_v.pa = 32'h7000_1000;
        do_access(dyn_v, "R11 second kept");
        dyn_v.va = 32'h0800_0000; dyn_v.miss = 1'b1;
        dyn_v.fframe = 20'h70000; dyn_v.pa = 32'h7000_0000;
        do_access(dyn_v, "R11 first evicted");

        // R13 requests during a walk are ignored
        @(negedge clk);
        xl_en = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0300_0000; req_write = 1'b0; req_priv = 1'b1;
        @(negedge clk);
        req_vaddr = 32'h0300_5000;
        check("R13 walk started", 32'(walk_req), 32'd1);
        check("R13 not ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R13 walk_vaddr kept", walk_vaddr, 32'h0300_0000);
        fill_valid = 1'b1; fill_section = 1'b0; fill_frame = 20'hABCDE;
        fill_dom = 4'h1; fill_perm = 2'h3; fill_bufable = 1'b0; fill_cacheable = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;
        check("R4 replay no resp yet", 32'(resp_valid), 32'd0);
        @(negedge clk);
        check("R13 resp_valid", 32'(resp_valid), 32'd1);
        check("R13 paddr for held", resp_paddr, 32'hABCD_E000);
        @(negedge clk);
        check("R13 single response", 32'(resp_valid), 32'd0);
        check("R13 no new walk", 32'(walk_req), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule